// File: doc/BRIEF.md
# Converter Power and Clock-Mode Manager

This block decides when a serial sampling converter is powered and which clock runs its successive-approximation conversion. It reads a three-level shutdown pin, which arrives already decoded as a two-bit code. It also reads the two mode bits of every accepted control byte, a pulse that marks a start bit, and a done pulse from the converter core, which is used when the conversion runs on the serial clock. From these it drives a powered flag, a one-cycle abort pulse, the internal/external clock selection, the internal oscillator rate selection and the strobe that is low while an internal-clock conversion is in progress.

The internal conversion clock is a clock-enable divider of the system clock. It runs at the fast rate when the shutdown pin floats and at the slow rate when the pin is driven high. An internal conversion lasts a fixed number of oscillator ticks. A software power-down request takes effect only after the conversion it was issued with has finished. A hardware shutdown stops everything at once and, when it is released, replays the power-on reset interval.

States: `ST_RESET` (power-on interval, control bytes ignored), `ST_IDLE` (powered, waiting), `ST_CONV_INT` (internal-clock conversion), `ST_CONV_EXT` (serial-clock conversion), `ST_SLEEP` (software power-down), `ST_HWOFF` (hardware shutdown). Transitions: RESET→IDLE when the interval expires; IDLE or SLEEP→CONV_INT or CONV_EXT on an accepted byte; CONV_*→CONV_* on a new byte (restart); CONV_INT→IDLE or SLEEP when the tick count completes; CONV_EXT→IDLE or SLEEP on `ext_done`; SLEEP→IDLE on a start bit; any state→HWOFF while the shutdown code is low; HWOFF→RESET when the code leaves low.

Top module: `pwr_clk_mgr`

## Requirements
- R1: After `rst_n` and during the reset interval, `pwr_up`=1, `clk_int`=1, `strobe_int`=1, `hold_result`=0, `abort_p`=0 and `mode_err`=0. Control bytes that arrive during the interval start nothing and leave `clk_int` unchanged.
- R2: The reset interval lasts RST_CYC system cycles (2000 at defaults, 10 us at 200 MHz). `hold_result` is 0 through cycle RST_CYC-1 after release and 1 in cycle RST_CYC.
- R3: Shutdown code 2'b00 means low. Code 2'b01 means open and gives `osc_fast`=1. Codes 2'b10 and 2'b11 mean high and give `osc_fast`=0.
- R4: While the shutdown code is low, `pwr_up` is 0 from the next cycle, whatever the mode bits, and control bytes are ignored.
- R5: A low shutdown code during a conversion gives a one-cycle `abort_p` in the next cycle and returns `strobe_int` high. When the code leaves low, the block replays the reset interval in internal-clock mode.
- R6: Mode bits 2'b10 start an internal conversion. `clk_int`=1, and `strobe_int` is low for exactly CONV_TICKS×DIV cycles (13×133 with the pin open, 13×888 with it high). The rate is the one in force when the byte was accepted.
- R7: Mode bits 2'b11 start a serial-clock conversion. `clk_int`=0, `strobe_int` stays high, the conversion ends on `ext_done`, and the block stays powered.
- R8: Mode bits 2'b00 run the conversion in the previously selected clock mode, then drop `pwr_up` in the cycle after the conversion ends.
- R9: After a software power-down, `hold_result` is 1 if the last conversion used the internal clock and 0 if it used the serial clock.
- R10: A start bit while in software power-down raises `pwr_up` in the next cycle.
- R11: Mode bits 2'b01 keep the previous clock mode and set `mode_err`, which stays set until `rst_n`. The block stays powered after that conversion.
- R12: A control byte accepted during a conversion gives a one-cycle `abort_p` and restarts the conversion from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-on) |
| sd_code | input | 2 | Decoded shutdown pin level: 00 low, 01 open, 10/11 high |
| ctrl_valid | input | 1 | One-cycle pulse: control byte accepted |
| ctrl_mode | input | 2 | Mode bits of that byte |
| start_seen | input | 1 | One-cycle pulse: start bit detected |
| ext_done | input | 1 | One-cycle pulse: serial-clock conversion finished |
| pwr_up | output | 1 | Converter powered |
| abort_p | output | 1 | One-cycle pulse: running conversion dropped |
| clk_int | output | 1 | 1 = internal conversion clock, 0 = serial clock |
| osc_fast | output | 1 | Internal oscillator rate select (1 = fast) |
| conv_tick | output | 1 | Internal conversion clock enable |
| strobe_int | output | 1 | Low while an internal conversion runs |
| hold_result | output | 1 | Result register retained and readable |
| mode_err | output | 1 | Sticky: unassigned mode code seen |

## Verification
Two pairs of functions can fall in the same cycle. A hardware shutdown can arrive while an internal conversion is counting ticks. A new control byte can arrive while an earlier conversion is still running, so a restart competes with that conversion's completion. The bench lowers the shutdown code mid-conversion and sends a second byte mid-conversion. In both cases it requires the abort pulse exactly one cycle after the stimulus, and for the restart it requires a full-length strobe counted from the restart cycle. Seeded random byte sequences then cross the mode codes with the two oscillator rates and with sleep and wake, and a bench model predicts the clock mode, strobe length, power and retention.

// File: rtl/pwr_clk_mgr_pkg.sv
package pwr_clk_mgr_pkg;

    typedef enum logic [2:0] {
        ST_RESET    = 3'd0,
        ST_IDLE     = 3'd1,
        ST_CONV_INT = 3'd2,
        ST_CONV_EXT = 3'd3,
        ST_SLEEP    = 3'd4,
        ST_HWOFF    = 3'd5
    } pm_state_t;

    localparam logic [1:0] SD_LOW  = 2'b00;
    localparam logic [1:0] SD_OPEN = 2'b01;

    localparam logic [1:0] MB_PDOWN = 2'b00;
    localparam logic [1:0] MB_BAD   = 2'b01;
    localparam logic [1:0] MB_INT   = 2'b10;
    localparam logic [1:0] MB_EXT   = 2'b11;

endpackage

// File: rtl/pwr_sd_decode.sv
module pwr_sd_decode
    import pwr_clk_mgr_pkg::*;
(
    input  logic [1:0] sd_code,
    output logic       sd_low,
    output logic       sd_fast
);

    // open level selects the fast oscillator; both high codes select slow
    always_comb begin
        sd_low  = (sd_code == SD_LOW);
        sd_fast = (sd_code == SD_OPEN);
    end

endmodule

// File: rtl/pwr_delay_cnt.sv
module pwr_delay_cnt #(
    parameter int LIMIT = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic done
);

    localparam int W = $clog2(LIMIT + 1);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (cnt_q != W'(LIMIT - 1)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done = !clr && (cnt_q == W'(LIMIT - 1));

    a_r2_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= W'(LIMIT - 1));

endmodule

// File: rtl/pwr_conv_timer.sv
module pwr_conv_timer #(
    parameter int DIV_FAST   = 133,
    parameter int DIV_SLOW   = 888,
    parameter int CONV_TICKS = 13
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    input  logic sel_fast,
    output logic tick,
    output logic done
);

    localparam int DIV_MAX = (DIV_FAST > DIV_SLOW) ? DIV_FAST : DIV_SLOW;
    localparam int CW      = $clog2(DIV_MAX + 1);
    localparam int TW      = $clog2(CONV_TICKS + 1);

    logic [CW-1:0] div_q;
    logic [CW-1:0] lim;
    logic [TW-1:0] ticks_q;

    assign lim  = sel_fast ? CW'(DIV_FAST - 1) : CW'(DIV_SLOW - 1);
    assign tick = en && !clr && (div_q == lim);
    assign done = tick && (ticks_q == TW'(CONV_TICKS - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (clr) begin
            div_q <= '0;
        end else if (en) begin
            div_q <= (div_q == lim) ? '0 : div_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ticks_q <= '0;
        end else if (clr) begin
            ticks_q <= '0;
        end else if (tick) begin
            ticks_q <= (ticks_q == TW'(CONV_TICKS - 1)) ? '0 : ticks_q + 1'b1;
        end
    end

    a_r6_ticks_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        ticks_q < TW'(CONV_TICKS));

    a_r6_div_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        div_q < CW'(DIV_MAX));

endmodule

// File: rtl/pwr_clk_mgr.sv
module pwr_clk_mgr
    import pwr_clk_mgr_pkg::*;
#(
    parameter int SYS_HZ     = 200_000_000,
    parameter int FAST_HZ    = 1_500_000,
    parameter int SLOW_HZ    = 225_000,
    parameter int RST_US     = 10,
    parameter int CONV_TICKS = 13
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] sd_code,
    input  logic       ctrl_valid,
    input  logic [1:0] ctrl_mode,
    input  logic       start_seen,
    input  logic       ext_done,
    output logic       pwr_up,
    output logic       abort_p,
    output logic       clk_int,
    output logic       osc_fast,
    output logic       conv_tick,
    output logic       strobe_int,
    output logic       hold_result,
    output logic       mode_err
);

    localparam int DIV_FAST = SYS_HZ / FAST_HZ;
    localparam int DIV_SLOW = SYS_HZ / SLOW_HZ;
    localparam int RST_CYC  = (SYS_HZ / 1_000_000) * RST_US;

    pm_state_t state_q, state_d;
    logic mode_int_q, mode_int_d;
    logic pd_pend_q, pd_pend_d;
    logic err_q, err_d;
    logic rate_fast_q, rate_fast_d;
    logic abort_q, abort_d;

    logic sd_low, sd_fast;
    logic in_conv, accept, new_int;
    logic rst_done, tmr_en, tmr_tick, tmr_done;

    pwr_sd_decode u_dec (
        .sd_code (sd_code),
        .sd_low  (sd_low),
        .sd_fast (sd_fast)
    );

    pwr_delay_cnt #(.LIMIT(RST_CYC)) u_rst_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state_q != ST_RESET),
        .done  (rst_done)
    );

    assign tmr_en = (state_q == ST_CONV_INT);

    pwr_conv_timer #(
        .DIV_FAST   (DIV_FAST),
        .DIV_SLOW   (DIV_SLOW),
        .CONV_TICKS (CONV_TICKS)
    ) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (accept),
        .en       (tmr_en),
        .sel_fast (rate_fast_q),
        .tick     (tmr_tick),
        .done     (tmr_done)
    );

    assign in_conv = (state_q == ST_CONV_INT) || (state_q == ST_CONV_EXT);
    assign accept  = ctrl_valid && !sd_low &&
                     ((state_q == ST_IDLE) || (state_q == ST_SLEEP) || in_conv);

    always_comb begin
        case (ctrl_mode)
            MB_INT:  new_int = 1'b1;
            MB_EXT:  new_int = 1'b0;
            default: new_int = mode_int_q;
        endcase
    end

    // next-state and data-register update
    always_comb begin
        state_d     = state_q;
        mode_int_d  = mode_int_q;
        pd_pend_d   = pd_pend_q;
        err_d       = err_q;
        rate_fast_d = rate_fast_q;
        abort_d     = 1'b0;
        unique case (state_q)
            ST_RESET: begin
                if (rst_done) state_d = ST_IDLE;
            end
            ST_IDLE: begin
            end
            ST_SLEEP: begin
                if (start_seen) state_d = ST_IDLE;
            end
            ST_CONV_INT: begin
                if (tmr_done) state_d = pd_pend_q ? ST_SLEEP : ST_IDLE;
            end
            ST_CONV_EXT: begin
                if (ext_done) state_d = pd_pend_q ? ST_SLEEP : ST_IDLE;
            end
            ST_HWOFF: begin
                state_d    = ST_RESET;
                mode_int_d = 1'b1;
                pd_pend_d  = 1'b0;
            end
            default: begin
                state_d = ST_RESET;
            end
        endcase
        if (accept) begin
            abort_d     = in_conv;
            mode_int_d  = new_int;
            pd_pend_d   = (ctrl_mode == MB_PDOWN);
            err_d       = err_q | (ctrl_mode == MB_BAD);
            rate_fast_d = sd_fast;
            state_d     = new_int ? ST_CONV_INT : ST_CONV_EXT;
        end
        if (sd_low) begin
            state_d    = ST_HWOFF;
            abort_d    = in_conv;
            mode_int_d = mode_int_q;
            pd_pend_d  = pd_pend_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_RESET;
            mode_int_q  <= 1'b1;
            pd_pend_q   <= 1'b0;
            err_q       <= 1'b0;
            rate_fast_q <= 1'b1;
            abort_q     <= 1'b0;
        end else begin
            state_q     <= state_d;
            mode_int_q  <= mode_int_d;
            pd_pend_q   <= pd_pend_d;
            err_q       <= err_d;
            rate_fast_q <= rate_fast_d;
            abort_q     <= abort_d;
        end
    end

    // Moore outputs
    always_comb begin
        pwr_up      = 1'b1;
        strobe_int  = 1'b1;
        hold_result = 1'b1;
        unique case (state_q)
            ST_RESET:    hold_result = 1'b0;
            ST_IDLE:     ;
            ST_CONV_INT: strobe_int = 1'b0;
            ST_CONV_EXT: ;
            ST_SLEEP: begin
                pwr_up      = 1'b0;
                hold_result = mode_int_q;
            end
            ST_HWOFF: begin
                pwr_up      = 1'b0;
                hold_result = 1'b0;
            end
            default: hold_result = 1'b0;
        endcase
        abort_p   = abort_q;
        clk_int   = mode_int_q;
        osc_fast  = sd_fast;
        conv_tick = tmr_tick;
        mode_err  = err_q;
    end

    a_r4_low_powers_off: assert property (@(posedge clk) disable iff (!rst_n)
        sd_low |=> !pwr_up);

    a_r5_abort_on_shutdown: assert property (@(posedge clk) disable iff (!rst_n)
        (in_conv && sd_low) |=> abort_p);

    a_r6_strobe_only_internal: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_int |-> clk_int);

    a_r1_reset_no_start: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RESET && !sd_low) |=> strobe_int);

    a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        mode_err |=> mode_err);

    a_r8_pd_after_ext_done: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CONV_EXT && ext_done && pd_pend_q && !ctrl_valid && !sd_low)
        |=> !pwr_up);

    a_r10_wake: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SLEEP && start_seen && !sd_low) |=> pwr_up);

    a_r12_abort_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        abort_p |=> !abort_p || $past(sd_low) || $past(ctrl_valid));

endmodule

// File: tb/pwr_clk_mgr_tb.sv
module pwr_clk_mgr_tb_top;

    localparam int RST_CYC  = 2000;
    localparam int DIV_F    = 133;
    localparam int DIV_S    = 888;
    localparam int TICKS    = 13;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] sd_code = 2'b01;
    logic       ctrl_valid = 1'b0;
    logic [1:0] ctrl_mode = 2'b00;
    logic       start_seen = 1'b0;
    logic       ext_done = 1'b0;
    logic pwr_up, abort_p, clk_int, osc_fast, conv_tick, strobe_int, hold_result, mode_err;

    int n_chk = 0;
    int n_bad = 0;
    int since_rst = 0;

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) since_rst <= 0;
        else        since_rst <= since_rst + 1;
    end

    pwr_clk_mgr dut_i (
        .clk(clk), .rst_n(rst_n), .sd_code(sd_code), .ctrl_valid(ctrl_valid),
        .ctrl_mode(ctrl_mode), .start_seen(start_seen), .ext_done(ext_done),
        .pwr_up(pwr_up), .abort_p(abort_p), .clk_int(clk_int), .osc_fast(osc_fast),
        .conv_tick(conv_tick), .strobe_int(strobe_int), .hold_result(hold_result),
        .mode_err(mode_err)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_len(input bit fast);
        return TICKS * (fast ? DIV_F : DIV_S);
    endfunction

    function automatic bit exp_int(input logic [1:0] mb, input bit cur);
        if (mb == 2'b10) return 1'b1;
        if (mb == 2'b11) return 1'b0;
        return cur;
    endfunction

    task automatic send_ctrl(input logic [1:0] mb);
        @(negedge clk); ctrl_valid = 1'b1; ctrl_mode = mb;
        @(negedge clk); ctrl_valid = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk); start_seen = 1'b1;
        @(negedge clk); start_seen = 1'b0;
    endtask

    task automatic pulse_done();
        @(negedge clk); ext_done = 1'b1;
        @(negedge clk); ext_done = 1'b0;
    endtask

    // counts strobe-low cycles starting at the current negedge
    task automatic measure(output int n, input int switch_at);
        n = 0;
        while (strobe_int == 1'b0) begin
            n++;
            if (n == switch_at) sd_code = 2'b10;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int len;
        bit m_int, m_err, asleep;
        logic [1:0] mb;
        bit fast;
        void'($urandom(32'd1245));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 pwr_up", pwr_up, 1);
        check("R1 clk_int", clk_int, 1);
        check("R1 strobe", strobe_int, 1);
        check("R1 hold", hold_result, 0);
        check("R1 abort", abort_p, 0);
        check("R1 err", mode_err, 0);
        repeat (100) @(negedge clk);
        send_ctrl(2'b11);
        check("R1 byte ignored clk_int", clk_int, 1);
        check("R1 byte ignored strobe", strobe_int, 1);
        pulse_start();
        // R2 interval length
        while (since_rst < RST_CYC - 1) @(negedge clk);
        check("R2 still in reset", hold_result, 0);
        @(negedge clk);
        check("R2 reset over", hold_result, 1);

        // R3 decode
        sd_code = 2'b01; @(negedge clk); check("R3 open fast", osc_fast, 1);
        sd_code = 2'b10; @(negedge clk); check("R3 high slow", osc_fast, 0);
        sd_code = 2'b11; @(negedge clk); check("R3 code11 slow", osc_fast, 0);
        sd_code = 2'b01; @(negedge clk);

        // R6 fast and slow internal conversion
        send_ctrl(2'b10);
        check("R6 clk_int", clk_int, 1);
        measure(len, 0);
        check("R6 fast length", len, exp_len(1));
        check("R6 powered after", pwr_up, 1);
        sd_code = 2'b10;
        send_ctrl(2'b10);
        measure(len, 0);
        check("R6 slow length", len, exp_len(0));
        sd_code = 2'b01;
        send_ctrl(2'b10);
        measure(len, 10);
        check("R6 rate latched at start", len, exp_len(1));
        sd_code = 2'b01;

        // R7 external
        send_ctrl(2'b11);
        check("R7 clk_int", clk_int, 0);
        check("R7 strobe high", strobe_int, 1);
        repeat (50) @(negedge clk);
        check("R7 powered", pwr_up, 1);
        pulse_done();
        check("R7 powered after done", pwr_up, 1);
        send_ctrl(2'b10);
        check("R7 ext ended (no abort)", abort_p, 0);

        // R12 restart during conversion
        repeat (200) @(negedge clk);
        send_ctrl(2'b10);
        check("R12 abort pulse", abort_p, 1);
        measure(len, 0);
        check("R12 restart length", len, exp_len(1));
        check("R12 abort cleared", abort_p, 0);

        // R8/R9 software power-down after internal conversion
        send_ctrl(2'b00);
        check("R8 previous mode internal", clk_int, 1);
        measure(len, 0);
        check("R8 internal length", len, exp_len(1));
        check("R8 powered down", pwr_up, 0);
        check("R9 hold after internal", hold_result, 1);

        // R10 wake, then power-down after external conversion
        pulse_start();
        check("R10 wake", pwr_up, 1);
        send_ctrl(2'b11);
        pulse_done();
        send_ctrl(2'b00);
        check("R8 previous mode external", clk_int, 0);
        check("R8 ext strobe high", strobe_int, 1);
        repeat (20) @(negedge clk);
        check("R8 up until done", pwr_up, 1);
        pulse_done();
        check("R8 down after done", pwr_up, 0);
        check("R9 no hold after external", hold_result, 0);

        // R11 unassigned mode code
        pulse_start();
        send_ctrl(2'b01);
        check("R11 mode kept", clk_int, 0);
        check("R11 err set", mode_err, 1);
        pulse_done();
        check("R11 stays up", pwr_up, 1);
        send_ctrl(2'b11);
        pulse_done();
        check("R11 err sticky", mode_err, 1);

        // R4/R5 hardware shutdown mid internal conversion
        send_ctrl(2'b10);
        repeat (100) @(negedge clk);
        sd_code = 2'b00;
        @(negedge clk);
        check("R4 pwr down", pwr_up, 0);
        check("R5 abort", abort_p, 1);
        check("R5 strobe high", strobe_int, 1);
        send_ctrl(2'b11);
        check("R4 byte ignored pwr", pwr_up, 0);
        check("R4 byte ignored abort", abort_p, 0);
        sd_code = 2'b01;
        @(negedge clk);
        check("R5 reset replay pwr", pwr_up, 1);
        check("R5 reset internal", clk_int, 1);
        check("R5 reset hold", hold_result, 0);
        repeat (RST_CYC - 1) @(negedge clk);
        check("R5 reset still running", hold_result, 0);
        @(negedge clk);
        check("R5 reset done", hold_result, 1);

        // random mix
        m_int = 1'b1; m_err = 1'b1; asleep = 1'b0;
        for (int it = 0; it < 14; it++) begin
            mb = 2'($urandom % 4);
            fast = ($urandom % 4) != 0;
            sd_code = fast ? 2'b01 : 2'b10;
            if (asleep) begin
                pulse_start();
                check("R10 rand wake", pwr_up, 1);
            end
            send_ctrl(mb);
            m_int = exp_int(mb, m_int);
            if (mb == 2'b01) m_err = 1'b1;
            check("R6/R7 rand clk_int", clk_int, m_int);
            if (m_int) begin
                measure(len, 0);
                check("R6 rand length", len, exp_len(fast));
            end else begin
                check("R7 rand strobe", strobe_int, 1);
                repeat (1 + ($urandom % 40)) @(negedge clk);
                pulse_done();
            end
            asleep = (mb == 2'b00);
            check("R8 rand power", pwr_up, asleep ? 0 : 1);
            check("R11 rand err", mode_err, m_err);
            check("R9 rand hold", hold_result, asleep ? m_int : 1);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule